// File: doc/BRIEF.md
# Quarter-Duty LCD Waveform Sequencer

This block turns a base timing tick into the drive waveforms of a four-common multiplexed LCD. It steps through the four common phases and produces a 2-bit level code for each common and each segment. An external analog ladder decodes these codes into VSS, the two intermediate levels or VDD. The display contents come from a segment RAM that exposes all its cells in parallel, with four bits per segment.

Configuration comes in on plain control pins and may change at any time. The pins cover the frame rate, line or frame polarity inversion, 1/2 or 1/3 bias coding, the blink rate, two all-pixel overrides and display enable. The block has no data stream and no handshake. The RAM bus is read combinationally, and a RAM change appears on the segment codes in the same cycle. The base tick is an enable: while it is low, the phase and blink timers hold.

Level codes: 0 = VSS, 1 = lower intermediate (VDD/3, or VDD/2 with 1/2 bias), 2 = upper intermediate (2·VDD/3), 3 = VDD. Segment `s` reads `ram_q[4*s + c]` during common phase `c`. Common `c` drives `com_lvl[2*c +: 2]`, and segment `s` drives `seg_lvl[2*s +: 2]`.

Top module: `lcdq_seq`

## Requirements
- R1: While reset is held and after it is released with `disp_en` low, every common and segment code is 0, the phase is common 0 and the polarity is positive.
- R2: With the display on, exactly one common is at a selected level (0 or 3) at any time. The selected common advances 0, 1, 2, 3, 0 and so on, one step per phase period.
- R3: The phase period is `round(BASE_HZ / (4·rate))` ticks. `rate_sel` 0/1/2/3 selects 80/71/64/53 Hz.
- R4: With `frame_inv` low (line inversion), the polarity flips at every phase step.
- R5: With `frame_inv` high (frame inversion), the polarity flips only on the step from common 3 back to common 0.
- R6: With 1/3 bias (`half_bias` low) and positive polarity, the codes are: selected common 3, unselected common 1, lit segment 0, dark segment 2. With negative polarity they are 0, 2, 3 and 1.
- R7: With 1/2 bias (`half_bias` high) and positive polarity, the codes are: selected common 3, unselected common 1, lit segment 0, dark segment 3. With negative polarity they are 0, 1, 3 and 0.
- R8: `blink_sel` 0 disables blinking. Values 1/2/3 give 0.5/1/2 Hz, so each shown and hidden half lasts `BASE_HZ`, `BASE_HZ/2` or `BASE_HZ/4` ticks. Each blink cycle starts with the shown half.
- R9: During the hidden half of a blink, every segment is driven to its dark level.
- R10: With `all_on` high and `all_off` low, every segment is driven to its lit level whatever the RAM holds.
- R11: With `all_off` high, every segment is driven to its dark level. This holds whatever `all_on` and the RAM hold.
- R12: With `disp_en` low, all outputs are 0. When the display is enabled again, the segments show the RAM pattern at once.
- R13: While `tick` is low, the phase and polarity do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Base timebase enable, one pulse per base period |
| disp_en | input | 1 | Display enable |
| rate_sel | input | 2 | Frame rate select |
| frame_inv | input | 1 | 1 = frame inversion, 0 = line inversion |
| half_bias | input | 1 | 1 = 1/2 bias coding, 0 = 1/3 bias coding |
| blink_sel | input | 2 | Blink rate select |
| all_on | input | 1 | Force all segments lit |
| all_off | input | 1 | Force all segments dark (wins over all_on) |
| ram_q | input | 4*NSEG | Segment RAM contents, 4 bits per segment |
| com_lvl | output | 8 | Common level codes |
| seg_lvl | output | 2*NSEG | Segment level codes |

## Verification
Sparse, irregular RAM patterns are run under line inversion and then under frame inversion. Only the correct pairing of common phase with RAM bit, and of polarity with phase step, reproduces the expected codes. Each bias coding is exercised over both polarities, so a swapped intermediate level shows up. The phase length is measured from the outputs for all four rates, and the hidden blink half is timed with an all-ones RAM. Both overrides, both at once, display off and a held tick are tried against a pattern that has lit and dark segments.

// File: rtl/lcdq_pkg.sv
package lcdq_pkg;
  localparam logic [1:0] LVL_VSS = 2'd0;
  localparam logic [1:0] LVL_LO  = 2'd1;
  localparam logic [1:0] LVL_HI  = 2'd2;
  localparam logic [1:0] LVL_VDD = 2'd3;

  function automatic logic [1:0] com_code(input logic sel, input logic neg, input logic half);
    if (sel) return neg ? LVL_VSS : LVL_VDD;
    if (half) return LVL_LO;
    return neg ? LVL_HI : LVL_LO;
  endfunction

  function automatic logic [1:0] seg_code(input logic lit, input logic neg, input logic half);
    if (lit) return neg ? LVL_VDD : LVL_VSS;
    if (half) return neg ? LVL_VSS : LVL_VDD;
    return neg ? LVL_LO : LVL_HI;
  endfunction
endpackage

// File: rtl/lcdq_timebase.sv
module lcdq_timebase #(
  parameter int BASE_HZ = 32768
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [1:0] rate_sel,
  input  logic       frame_inv,
  output logic [1:0] phase,
  output logic       pol
);
  localparam int D0 = (BASE_HZ + 160) / 320;
  localparam int D1 = (BASE_HZ + 142) / 284;
  localparam int D2 = (BASE_HZ + 128) / 256;
  localparam int D3 = (BASE_HZ + 106) / 212;
  localparam int CW = $clog2(D3 + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] last;

  always_comb begin
    case (rate_sel)
      2'd0:    last = CW'(D0 - 1);
      2'd1:    last = CW'(D1 - 1);
      2'd2:    last = CW'(D2 - 1);
      default: last = CW'(D3 - 1);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      phase <= 2'd0;
      pol   <= 1'b0;
    end else if (tick) begin
      if (cnt >= last) begin
        cnt   <= '0;
        phase <= phase + 2'd1;
        if (!frame_inv || phase == 2'd3) pol <= ~pol;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/lcdq_blink.sv
module lcdq_blink #(
  parameter int BASE_HZ = 32768
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [1:0] blink_sel,
  output logic       shown
);
  localparam int BW = $clog2(BASE_HZ + 1);

  logic [BW-1:0] cnt;
  logic [BW-1:0] last;

  always_comb begin
    case (blink_sel)
      2'd1:    last = BW'(BASE_HZ - 1);
      2'd2:    last = BW'(BASE_HZ / 2 - 1);
      default: last = BW'(BASE_HZ / 4 - 1);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      shown <= 1'b1;
    end else if (blink_sel == 2'd0) begin
      cnt   <= '0;
      shown <= 1'b1;
    end else if (tick) begin
      if (cnt >= last) begin
        cnt   <= '0;
        shown <= ~shown;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/lcdq_encoder.sv
module lcdq_encoder
  import lcdq_pkg::*;
#(
  parameter int NSEG = 35
) (
  input  logic [1:0]        phase,
  input  logic              pol,
  input  logic              half_bias,
  input  logic              shown,
  input  logic              all_on,
  input  logic              all_off,
  input  logic              disp_en,
  input  logic [4*NSEG-1:0] ram_q,
  output logic [7:0]        com_lvl,
  output logic [2*NSEG-1:0] seg_lvl
);
  for (genvar c = 0; c < 4; c++) begin : g_com
    assign com_lvl[2*c +: 2] = disp_en ? com_code(phase == 2'(c), pol, half_bias) : LVL_VSS;
  end

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    logic [3:0] nib;
    logic       lit;
    assign nib = ram_q[4*s +: 4];
    always_comb begin
      if (all_off)      lit = 1'b0;
      else if (all_on)  lit = 1'b1;
      else if (!shown)  lit = 1'b0;
      else              lit = nib[phase];
    end
    assign seg_lvl[2*s +: 2] = disp_en ? seg_code(lit, pol, half_bias) : LVL_VSS;
  end
endmodule

// File: rtl/lcdq_seq.sv
module lcdq_seq #(
  parameter int NSEG    = 35,
  parameter int BASE_HZ = 32768
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              disp_en,
  input  logic [1:0]        rate_sel,
  input  logic              frame_inv,
  input  logic              half_bias,
  input  logic [1:0]        blink_sel,
  input  logic              all_on,
  input  logic              all_off,
  input  logic [4*NSEG-1:0] ram_q,
  output logic [7:0]        com_lvl,
  output logic [2*NSEG-1:0] seg_lvl
);
  logic [1:0] phase_w;
  logic       pol_w;
  logic       shown_w;

  lcdq_timebase #(.BASE_HZ(BASE_HZ)) tb_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rate_sel(rate_sel),
    .frame_inv(frame_inv), .phase(phase_w), .pol(pol_w)
  );

  lcdq_blink #(.BASE_HZ(BASE_HZ)) bl_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .blink_sel(blink_sel), .shown(shown_w)
  );

  lcdq_encoder #(.NSEG(NSEG)) enc_i (
    .phase(phase_w), .pol(pol_w), .half_bias(half_bias), .shown(shown_w),
    .all_on(all_on), .all_off(all_off), .disp_en(disp_en), .ram_q(ram_q),
    .com_lvl(com_lvl), .seg_lvl(seg_lvl)
  );
endmodule

// File: rtl/lcdq_seq_chk.sv
module lcdq_seq_chk #(
  parameter int NSEG = 35
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              disp_en,
  input logic              frame_inv,
  input logic              all_off,
  input logic [7:0]        com_lvl,
  input logic [2*NSEG-1:0] seg_lvl,
  input logic [1:0]        phase,
  input logic              pol
);
  logic [3:0] extreme;
  logic       seg_same;

  always_comb begin
    for (int c = 0; c < 4; c++)
      extreme[c] = (com_lvl[2*c +: 2] == 2'd0) || (com_lvl[2*c +: 2] == 2'd3);
    seg_same = 1'b1;
    for (int s = 1; s < NSEG; s++)
      if (seg_lvl[2*s +: 2] != seg_lvl[1:0]) seg_same = 1'b0;
  end

  a_r12_off_all_vss: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_en |-> (com_lvl == 8'd0 && seg_lvl == '0));

  a_r2_one_selected: assert property (@(posedge clk) disable iff (!rst_n)
    disp_en |-> $countones(extreme) == 1);

  a_r2_step_order: assert property (@(posedge clk) disable iff (!rst_n)
    phase != $past(phase) |-> phase == $past(phase) + 2'd1);

  a_r13_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(phase) && $stable(pol)));

  a_r4_line_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(frame_inv) && phase != $past(phase)) |-> pol != $past(pol));

  a_r5_frame_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(frame_inv) && phase != $past(phase) && $past(phase) != 2'd3) |-> pol == $past(pol));

  a_r4_flip_only_on_step: assert property (@(posedge clk) disable iff (!rst_n)
    pol != $past(pol) |-> phase != $past(phase));

  a_r11_uniform_dark: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_en && all_off) |-> seg_same);
endmodule

bind lcdq_seq lcdq_seq_chk #(.NSEG(NSEG)) chk_i (
  .clk(clk), .rst_n(rst_n), .tick(tick), .disp_en(disp_en), .frame_inv(frame_inv),
  .all_off(all_off), .com_lvl(com_lvl), .seg_lvl(seg_lvl), .phase(phase_w), .pol(pol_w)
);

// File: tb/lcdq_seq_tb_top.sv
module lcdq_seq_tb_top;
  localparam int NSEG = 8;
  localparam int BASE = 4096;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b1;
  logic disp_en = 1'b0;
  logic [1:0] rate_sel = 2'd0;
  logic frame_inv = 1'b0;
  logic half_bias = 1'b0;
  logic [1:0] blink_sel = 2'd0;
  logic all_on = 1'b0;
  logic all_off = 1'b0;
  logic [4*NSEG-1:0] ram_q = '0;
  logic [7:0] com_lvl;
  logic [2*NSEG-1:0] seg_lvl;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  lcdq_seq #(.NSEG(NSEG), .BASE_HZ(BASE)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .disp_en(disp_en), .rate_sel(rate_sel),
    .frame_inv(frame_inv), .half_bias(half_bias), .blink_sel(blink_sel),
    .all_on(all_on), .all_off(all_off), .ram_q(ram_q), .com_lvl(com_lvl), .seg_lvl(seg_lvl)
  );

  function automatic int div_of(input logic [1:0] r);
    int hz;
    hz = (r == 0) ? 80 : (r == 1) ? 71 : (r == 2) ? 64 : 53;
    return (BASE + 2 * hz) / (4 * hz);
  endfunction

  function automatic int half_of(input logic [1:0] b);
    return (b == 1) ? BASE : (b == 2) ? BASE / 2 : BASE / 4;
  endfunction

  // reference timing model built from R3, R4, R5, R8, R13
  int m_cnt, m_bcnt;
  logic [1:0] m_phase;
  logic m_pol, m_shown;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_bcnt = 0; m_phase = 0; m_pol = 0; m_shown = 1;
    end else begin
      if (blink_sel == 0) begin
        m_bcnt = 0; m_shown = 1;
      end
      if (tick) begin
        if (m_cnt >= div_of(rate_sel) - 1) begin
          m_cnt = 0;
          if (!frame_inv || m_phase == 3) m_pol = ~m_pol;
          m_phase = m_phase + 1;
        end else m_cnt++;
        if (blink_sel != 0) begin
          if (m_bcnt >= half_of(blink_sel) - 1) begin
            m_bcnt = 0; m_shown = ~m_shown;
          end else m_bcnt++;
        end
      end
    end
  end

  // code tables of R6 / R7
  function automatic logic [1:0] e_com(input bit sel, input bit neg, input bit half);
    if (sel) return neg ? 2'd0 : 2'd3;
    if (half) return 2'd1;
    return neg ? 2'd2 : 2'd1;
  endfunction
  function automatic logic [1:0] e_seg(input bit lit, input bit neg, input bit half);
    if (lit) return neg ? 2'd3 : 2'd0;
    if (half) return neg ? 2'd0 : 2'd3;
    return neg ? 2'd1 : 2'd2;
  endfunction

  task automatic fail(input string req, input string what, input int act, input int exp);
    errors++;
    $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
  endtask

  task automatic cmp(input string req);
    logic [1:0] ec, es;
    bit lit, bad;
    bad = 0;
    checks++;
    for (int c = 0; c < 4 && !bad; c++) begin
      ec = disp_en ? e_com(m_phase == c, m_pol, half_bias) : 2'd0;
      if (com_lvl[2*c +: 2] !== ec) begin
        fail(req, $sformatf("com%0d", c), com_lvl[2*c +: 2], ec); bad = 1;
      end
    end
    for (int s = 0; s < NSEG && !bad; s++) begin
      if (all_off) lit = 0;
      else if (all_on) lit = 1;
      else lit = m_shown && ram_q[4*s + m_phase];
      es = disp_en ? e_seg(lit, m_pol, half_bias) : 2'd0;
      if (seg_lvl[2*s +: 2] !== es) begin
        fail(req, $sformatf("seg%0d", s), seg_lvl[2*s +: 2], es); bad = 1;
      end
    end
  endtask

  task automatic run_cmp(input int n, input string req);
    repeat (n) begin
      @(negedge clk);
      cmp(req);
    end
  endtask

  function automatic int sel_idx();
    for (int c = 0; c < 4; c++)
      if (com_lvl[2*c +: 2] == 2'd0 || com_lvl[2*c +: 2] == 2'd3) return c;
    return -1;
  endfunction

  // R1
  task automatic t_reset();
    @(negedge clk);
    checks++;
    if (com_lvl !== 8'd0 || seg_lvl !== '0) fail("R1", "outputs in reset", int'(com_lvl), 0);
    rst_n = 1'b1;
    run_cmp(20, "R1");
  endtask

  // R2 R4 R6
  task automatic t_line_third();
    ram_q = 32'hA5C3_1E69;
    disp_en = 1'b1;
    run_cmp(13 * 4 * 3, "R2/R4/R6");
  endtask

  // R5
  task automatic t_frame();
    frame_inv = 1'b1;
    ram_q = 32'h0F81_7246;
    run_cmp(13 * 4 * 3, "R5");
    frame_inv = 1'b0;
  endtask

  // R7
  task automatic t_half();
    half_bias = 1'b1;
    run_cmp(13 * 4 * 3, "R7");
    frame_inv = 1'b1;
    run_cmp(13 * 4 * 2, "R7");
    frame_inv = 1'b0;
    half_bias = 1'b0;
  endtask

  // R3
  task automatic t_rates();
    int p, n, k;
    for (int r = 3; r >= 0; r--) begin
      rate_sel = 2'(r);
      for (int step = 0; step < 2; step++) begin
        p = sel_idx(); k = 0;
        do begin @(negedge clk); k++; end while (sel_idx() == p && k < 100);
      end
      p = sel_idx(); n = 0;
      do begin @(negedge clk); n++; end while (sel_idx() == p && n < 100);
      checks++;
      if (n != div_of(2'(r))) fail("R3", $sformatf("phase length rate %0d", r), n, div_of(2'(r)));
      run_cmp(div_of(2'(r)) * 4, "R3");
    end
    rate_sel = 2'd0;
  endtask

  function automatic bit seg0_lit();
    int c;
    c = sel_idx();
    if (c < 0) return 0;
    // polarity is read from the selected common level
    return (com_lvl[2*c +: 2] == 2'd3) ? (seg_lvl[1:0] == 2'd0) : (seg_lvl[1:0] == 2'd3);
  endfunction

  // R8 R9
  task automatic t_blink();
    int n, k;
    ram_q = '1;
    blink_sel = 2'd3;
    k = 0;
    do begin @(negedge clk); k++; end while (seg0_lit() && k < 5000);
    n = 0;
    do begin @(negedge clk); n++; end while (!seg0_lit() && n < 5000);
    checks++;
    if (n != BASE / 4) fail("R8", "hidden half length", n, BASE / 4);
    ram_q = 32'h3C5A_9617;
    run_cmp(2200, "R9");
    blink_sel = 2'd2;
    run_cmp(2200, "R8");
    blink_sel = 2'd1;
    run_cmp(600, "R8");
    blink_sel = 2'd0;
    run_cmp(30, "R8");
  endtask

  // R10 R11
  task automatic t_override();
    ram_q = 32'h0000_F00F;
    all_on = 1'b1;
    run_cmp(60, "R10");
    all_off = 1'b1;
    run_cmp(60, "R11");
    all_on = 1'b0;
    run_cmp(60, "R11");
    all_off = 1'b0;
    run_cmp(20, "R10");
  endtask

  // R12
  task automatic t_display_off();
    disp_en = 1'b0;
    run_cmp(40, "R12");
    disp_en = 1'b1;
    run_cmp(60, "R12");
  endtask

  // R13
  task automatic t_hold();
    logic [7:0] c0;
    @(negedge clk);
    tick = 1'b0;
    @(negedge clk);
    c0 = com_lvl;
    repeat (100) @(negedge clk);
    checks++;
    if (com_lvl !== c0) fail("R13", "com held", int'(com_lvl), int'(c0));
    run_cmp(10, "R13");
    tick = 1'b1;
    run_cmp(60, "R13");
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_line_third();
    t_frame();
    t_half();
    t_rates();
    t_blink();
    t_override();
    t_display_off();
    t_hold();
    summary();
  end
endmodule